// File: doc/BRIEF.md
# Signed-Magnitude Adder-Subtractor

This block adds or subtracts two operands held in signed-magnitude form and returns a signed-magnitude result of the same width. The top bit of each word is the sign and the remaining bits are an unsigned magnitude. A mode input chooses addition or subtraction. Subtraction is handled by negating the second operand, which in this format means inverting only its sign bit. The result then goes through the same path as an addition.

Internally, the effective signs decide which operation the magnitudes need. Equal signs add the magnitudes and keep the shared sign. Unequal signs subtract the smaller magnitude from the larger, and the result takes the sign of the operand with the larger magnitude. The block also raises a flag when the magnitude sum does not fit, and a flag for a zero result. Zero is always given out as the all-zeros word. The whole unit is combinational.

Top module: `smas_unit`

## Requirements
- R1: Word format and mode. In each word, bit N-1 is the sign (0 positive, 1 negative) and bits N-2..0 are the magnitude. The value range is -(2^(N-1)-1) to +(2^(N-1)-1). subMode=0 computes opA+opB and subMode=1 computes opA-opB.
- R2: When the effective signs match, the result magnitude is magA+magB and the result sign is the shared sign.
- R3: When the effective signs differ, the result magnitude is the larger magnitude minus the smaller one, and the result sign is the sign of the operand with the larger magnitude.
- R4: In subtract mode, opB is treated as the same magnitude with its sign bit inverted, and the result equals the addition of that word.
- R5: If a same-sign magnitude sum exceeds 2^(N-1)-1, overflow is 1, the result holds the shared sign and the low N-1 bits of the sum, and zero is 0.
- R6: A result that is exactly zero is given as all bits 0 with zero=1 and overflow=0. This includes equal magnitudes of opposite effective sign.
- R7: Negative zero (sign 1, magnitude 0) on either input behaves exactly like positive zero.
- R8: overflow is never 1 when the effective signs differ.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opA | input | N | First operand, signed magnitude |
| opB | input | N | Second operand, signed magnitude |
| subMode | input | 1 | 0 selects add, 1 selects subtract |
| result | output | N | Signed-magnitude result |
| overflow | output | 1 | Magnitude sum did not fit in N-1 bits |
| zero | output | 1 | Result is zero |

## Verification
All three outputs are combinational, so each result is due in the same clock cycle as the operands that produce it. The bench drives the operands just after a rising edge and compares them at the following falling edge. At that point the outputs have settled and no new stimulus has been applied. The bench sweeps every operand pair for N=5 in both modes. Each expected item is computed from an integer model of the sign and magnitude fields and queued when its stimulus is driven, so every item is checked in its own cycle.

// File: rtl/smas_pkg.sv
package smas_pkg;
  typedef struct packed {
    logic doSub;    // magnitudes are subtracted
    logic swap;     // B magnitude is the larger, subtract A from B
    logic signRaw;  // sign before canonical-zero forcing
  } smas_ctrl_t;
endpackage

// File: rtl/smas_control.sv
module smas_control
  import smas_pkg::*;
(
  input  logic       signA,
  input  logic       signB,
  input  logic       subMode,
  input  logic       aGeB,
  output smas_ctrl_t ctrl
);
  logic signBEff;

  always_comb begin
    signBEff = signB ^ subMode;
    ctrl.doSub = signA ^ signBEff;
    ctrl.swap = ctrl.doSub & ~aGeB;
    ctrl.signRaw = ctrl.swap ? signBEff : signA;
  end
endmodule

// File: rtl/smas_datapath.sv
module smas_datapath
  import smas_pkg::*;
#(
  parameter int N = 8
) (
  input  logic [N-2:0] magA,
  input  logic [N-2:0] magB,
  input  smas_ctrl_t   ctrl,
  output logic         aGeB,
  output logic [N-1:0] result,
  output logic         overflow,
  output logic         zero
);
  localparam int M = N - 1;

  logic [M:0]   sumWide;
  logic [M-1:0] bigMag;
  logic [M-1:0] smallMag;
  logic [M-1:0] diffMag;
  logic [M-1:0] magOut;
  logic         carryOut;
  logic         magIsZero;

  always_comb begin
    aGeB = (magA >= magB);
    sumWide = {1'b0, magA} + {1'b0, magB};
    carryOut = sumWide[M];
    bigMag = ctrl.swap ? magB : magA;
    smallMag = ctrl.swap ? magA : magB;
    diffMag = bigMag - smallMag;
    magOut = ctrl.doSub ? diffMag : sumWide[M-1:0];
    overflow = ~ctrl.doSub & carryOut;
    magIsZero = (magOut == '0);
    zero = magIsZero & ~overflow;
    result = {ctrl.signRaw & ~zero, magOut};
  end
endmodule

// File: rtl/smas_unit.sv
module smas_unit
  import smas_pkg::*;
#(
  parameter int N = 8
) (
  input  logic [N-1:0] opA,
  input  logic [N-1:0] opB,
  input  logic         subMode,
  output logic [N-1:0] result,
  output logic         overflow,
  output logic         zero
);
  smas_ctrl_t ctrl;
  logic       aGeB;

  smas_control u_control (
    .signA  (opA[N-1]),
    .signB  (opB[N-1]),
    .subMode(subMode),
    .aGeB   (aGeB),
    .ctrl   (ctrl)
  );

  smas_datapath #(.N(N)) u_datapath (
    .magA    (opA[N-2:0]),
    .magB    (opB[N-2:0]),
    .ctrl    (ctrl),
    .aGeB    (aGeB),
    .result  (result),
    .overflow(overflow),
    .zero    (zero)
  );
endmodule

// File: rtl/smas_checker.sv
module smas_checker #(
  parameter int N = 8
) (
  input logic [N-1:0] opA,
  input logic [N-1:0] opB,
  input logic         subMode,
  input logic [N-1:0] result,
  input logic         overflow,
  input logic         zero
);
  logic known;
  logic sA, sB;
  logic [N-2:0] mA, mB;

  always_comb begin
    known = !$isunknown({opA, opB, subMode, result, overflow, zero});
    sA = opA[N-1];
    sB = opB[N-1] ^ subMode;
    mA = opA[N-2:0];
    mB = opB[N-2:0];
    if (known) begin
      a_r6_zero_canonical: assert (!zero || result == '0)
        else $error("zero flag with nonzero result");
      a_r5_ovf_not_zero: assert (!(overflow && zero))
        else $error("overflow and zero together");
      a_r8_no_ovf_mixed: assert (sA == sB || !overflow)
        else $error("overflow on mixed signs");
      a_r2_sign_kept: assert (sA != sB || result[N-2:0] == '0 || result[N-1] == sA)
        else $error("same-sign result lost its sign");
      a_r3_larger_wins: assert (sA == sB || mA == mB ||
                                result == {(mA > mB) ? sA : sB,
                                           (mA > mB) ? mA - mB : mB - mA})
        else $error("mixed-sign result wrong");
    end
  end
endmodule

bind smas_unit smas_checker #(.N(N)) u_chk (.*);

// File: tb/smas_unit_bench.sv
module smas_unit_bench;
  localparam int N = 5;
  localparam int M = N - 1;
  localparam int MAXMAG = (1 << M) - 1;

  typedef struct {
    logic [N-1:0] a;
    logic [N-1:0] b;
    logic         sub;
    logic [N-1:0] expRes;
    logic         expOv;
    logic         expZ;
    int           tag;
  } item_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0] opA = '0;
  logic [N-1:0] opB = '0;
  logic subMode = 1'b0;
  logic [N-1:0] result;
  logic overflow;
  logic zero;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  item_t q[$];

  always #5 clk = ~clk;

  smas_unit #(.N(N)) u_smas_unit (
    .opA(opA), .opB(opB), .subMode(subMode),
    .result(result), .overflow(overflow), .zero(zero)
  );

  function automatic string tagName(int t);
    case (t)
      1: return "R1/R2";
      2: return "R3";
      3: return "R5";
      4: return "R6/R8";
      5: return "R7";
      6: return "R4";
      default: return "R6";
    endcase
  endfunction

  task automatic drive(input logic [N-1:0] a, input logic [N-1:0] b, input logic s);
    item_t it;
    int va, vb, sum, mag;
    bit neg;
    va = a[N-1] ? -int'(a[M-1:0]) : int'(a[M-1:0]);
    vb = b[N-1] ? -int'(b[M-1:0]) : int'(b[M-1:0]);
    if (s) vb = -vb;
    sum = va + vb;
    neg = (sum < 0);
    mag = neg ? -sum : sum;
    it.a = a; it.b = b; it.sub = s;
    it.expOv = (mag > MAXMAG);
    it.expZ = (mag == 0);
    it.expRes = {neg, M'(mag % (MAXMAG + 1))};
    if (it.expOv) it.tag = 3;
    else if (it.expZ && ((a[N-1] && a[M-1:0] == 0) || (b[N-1] && b[M-1:0] == 0))) it.tag = 5;
    else if (it.expZ) it.tag = 4;
    else if (s) it.tag = 6;
    else if ((a[N-1] ^ b[N-1] ^ s) != 1'b0) it.tag = 2;
    else it.tag = 1;
    @(posedge clk);
    #1;
    opA = a; opB = b; subMode = s;
    q.push_back(it);
  endtask

  always @(negedge clk) begin
    if (!rst && q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      checks++;
      if (result !== it.expRes || overflow !== it.expOv || zero !== it.expZ) begin
        errors++;
        $display("FAIL %s a=%b b=%b sub=%b actual res=%b ov=%b z=%b expected res=%b ov=%b z=%b",
                 tagName(it.tag), it.a, it.b, it.sub, result, overflow, zero,
                 it.expRes, it.expOv, it.expZ);
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R6: idle state with zero operands gives canonical zero
    checks++;
    if (result !== '0 || zero !== 1'b1 || overflow !== 1'b0) begin
      errors++;
      $display("FAIL R6 reset state actual res=%b z=%b ov=%b expected 0 1 0", result, zero, overflow);
    end
    // directed corners: R7 negative zeros, R5 max sum, R3 equal magnitudes
    drive(5'b10000, 5'b10000, 1'b0);
    drive(5'b10000, 5'b00000, 1'b1);
    drive(5'b01111, 5'b00001, 1'b0);
    drive(5'b11111, 5'b01111, 1'b1);
    drive(5'b00110, 5'b10110, 1'b0);
    drive(5'b10011, 5'b00111, 1'b0);
    // full sweep, both modes (R1, R2, R3, R4, R8)
    for (int s = 0; s < 2; s++)
      for (int a = 0; a < (1 << N); a++)
        for (int b = 0; b < (1 << N); b++)
          drive(N'(a), N'(b), 1'(s));
    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule